// File: doc/BRIEF.md
# Five-Bit Identification Test Access Port

This block is the target side of an IEEE 1149.1 test access port. It follows the sixteen-state TAP state machine on the test clock and holds a five-bit instruction register. It implements three instructions. One scans out a fixed 32-bit identification word. One places a one-bit bypass stage between the data input and output. One does the same and also tells the surrounding core to float its three-state pins through the `highzEn` output.

The host moves the state machine with the mode input, sampled on rising test-clock edges. Instructions and data enter least significant bit first. The serial output changes on falling edges, and its enable is high only while a shift state is active. An active-low asynchronous reset input returns the port to its reset state without a clock. The identification word is assembled from three parameters: a version, a part number and a manufacturer code.

Top module: `scan_tap`

## Requirements
- R1: Driving `trstN` low forces Test-Logic-Reset at once, with no test-clock edge needed. The active instruction becomes the identification instruction, and `highzEn` and `tdoEn` both go low while `trstN` is low.
- R2: Five rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. By the fifth edge the active instruction is the identification instruction, so `highzEn` is low there.
- R3: `tdo` and `tdoEn` change only on falling `tck` edges. `tdoEn` is high only while the state is Shift-IR or Shift-DR.
- R4: The instruction register is 5 bits wide. Bit 0 is next to `tdo` and `tdi` enters at bit 4, so codes go in least significant bit first. Capture-IR loads 5'b00001, so the first five bits out are 1,0,0,0,0. A new code takes effect on the rising edge that leaves Update-IR, and the code does not change in any other state apart from the reset state.
- R5: Code 5'b11110 selects the 32-bit identification register. Capture-DR loads the identification word into it, and Shift-DR moves the word out least significant bit first.
- R6: Data shifted in on `tdi` never alters the identification word. A later capture returns the same word again.
- R7: Code 5'b11111 selects the one-bit bypass stage. It captures 0, so a scan returns 0 first and then `tdi` delayed by one shift.
- R8: Code 5'b01000 drives `highzEn` high for as long as it is the active instruction, and it uses the bypass stage for data scans.
- R9: Every code other than 5'b11110 and 5'b01000 acts as bypass and keeps `highzEn` low. This includes codes one bit away from the defined ones.
- R10: In the identification word, bits 31:28 hold `ID_VERSION`, bits 27:12 hold `ID_PART` and bits 11:0 hold `ID_MFR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdoEn | output | 1 | Output enable for `tdo`, high in the shift states |
| highzEn | output | 1 | Request to float the core's three-state pins |

## Verification
The instruction register is loaded with the identification code and with the bypass code. It is also loaded with the float code, with all-zero and alternating codes, and with a code one bit away from the identification code. This separates correct opcode decoding from decoding that looks at only a few bits. Data scans use walking, all-ones and sparse patterns. These tell an exact one-shift bypass delay apart from a zero-length or inverted path, and show that identification scans ignore `tdi`. Directed scans leave the float instruction active and then enter reset in two ways: through five high `tms` edges from inside Shift-DR, and through `trstN` asserted midway through a clock period. Each case shows whether the port returns to the identification instruction.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W = 5;

  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b11110;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 5'b01000;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from the state machine to the datapath
  typedef struct packed {
    logic irToId;   // next state is Test-Logic-Reset
    logic capIr;
    logic shfIr;
    logic updIr;
    logic capDr;
    logic shfDr;
  } tapStb_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  output tapState_e state,
  output tapStb_t   stb
);

  tapState_e nextState;

  always_comb begin
    case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    stb.irToId = (nextState == ST_RESET);
    stb.capIr  = (state == ST_CAP_IR);
    stb.shfIr  = (state == ST_SHF_IR);
    stb.updIr  = (state == ST_UPD_IR);
    stb.capDr  = (state == ST_CAP_DR);
    stb.shfDr  = (state == ST_SHF_DR);
  end

endmodule

// File: rtl/scan_tap_dp.sv
`timescale 1ns/1ps
module scan_tap_dp
  import scan_tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  tapStb_t         stb,
  output logic            tdo,
  output logic            tdoEn,
  output logic            highzEn,
  output logic [IR_W-1:0] curIr
);

  logic [IR_W-1:0] irShift;
  logic [ID_W-1:0] idShift;
  logic            bypassQ;
  logic            selId;

  assign selId   = (curIr == OP_IDCODE);
  assign highzEn = (curIr == OP_HIGHZ);

  // instruction shift stage and active instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      curIr   <= OP_IDCODE;
    end else begin
      if (stb.capIr)      irShift <= IR_CAPTURE;
      else if (stb.shfIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (stb.irToId)     curIr <= OP_IDCODE;
      else if (stb.updIr) curIr <= irShift;
    end
  end

  // data registers: identification chain and bypass stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= ID_VALUE;
      bypassQ <= 1'b0;
    end else if (selId) begin
      if (stb.capDr)      idShift <= ID_VALUE;
      else if (stb.shfDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end else begin
      if (stb.capDr)      bypassQ <= 1'b0;
      else if (stb.shfDr) bypassQ <= tdi;
    end
  end

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= stb.shfIr ? irShift[0] : (selId ? idShift[0] : bypassQ);
      tdoEn <= stb.shfIr | stb.shfDr;
    end
  end

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'h5A17,
  parameter logic [11:0] ID_MFR     = 12'h0B3
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoEn,
  output logic highzEn
);

  localparam int ID_W = $bits(ID_VERSION) + $bits(ID_PART) + $bits(ID_MFR);
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR};

  tapState_e       state;
  tapStb_t         stb;
  logic [IR_W-1:0] curIr;

  scan_tap_ctrl u_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .state (state),
    .stb   (stb)
  );

  scan_tap_dp #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dp (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .stb     (stb),
    .tdo     (tdo),
    .tdoEn   (tdoEn),
    .highzEn (highzEn),
    .curIr   (curIr)
  );

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input logic            tdoEn,
  input logic            highzEn,
  input tapState_e       state,
  input logic [IR_W-1:0] curIr
);

  logic [2:0] tmsRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)           tmsRun <= '0;
    else if (!tms)        tmsRun <= '0;
    else if (tmsRun != 5) tmsRun <= tmsRun + 3'd1;
  end

  p_five_tms_reset_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == 3'd5) |-> (state == ST_RESET));

  p_reset_idcode_r2: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_RESET) |-> (curIr == OP_IDCODE && !highzEn));

  p_tdo_en_shift_r3: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (state == ST_SHF_IR || state == ST_SHF_DR));

  p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_IDLE || state == ST_SHF_DR || state == ST_SHF_IR) |=> $stable(curIr));

  p_highz_follows_ir_r8: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_UPD_DR) |=> $stable(highzEn));

endmodule

bind scan_tap scan_tap_chk i_chk (
  .tck     (tck),
  .trstN   (trstN),
  .tms     (tms),
  .tdoEn   (tdoEn),
  .highzEn (highzEn),
  .state   (state),
  .curIr   (curIr)
);

// File: tb/test_scan_tap.sv
`timescale 1ns/1ps
module test_scan_tap;

  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PART = 16'h5A17;
  localparam logic [11:0] MFR  = 12'h0B3;
  localparam logic [31:0] IDW  = {VER, PART, MFR};

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] din;
    logic        isId;
    logic        hz;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{5'b11110, 32'hFFFF_0000, 1'b1, 1'b0},
    '{5'b11111, 32'hA5C3_0F96, 1'b0, 1'b0},
    '{5'b01000, 32'h1234_5678, 1'b0, 1'b1},
    '{5'b00000, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{5'b10101, 32'h8000_0001, 1'b0, 1'b0},
    '{5'b11110, 32'h0F0F_F0F0, 1'b1, 1'b0},
    '{5'b01111, 32'h6DB6_DB6D, 1'b0, 1'b0}
  };

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn, highzEn;
  int   nChk = 0;
  int   nBad = 0;
  bit   done = 0;

  always #4 tck = ~tck;

  scan_tap #(.ID_VERSION(VER), .ID_PART(PART), .ID_MFR(MFR)) i_scan_tap (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .highzEn(highzEn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive inputs for the coming rising edge, sample outputs of the present state
  task automatic tick(input logic m, input logic d, output logic o, output logic en, output logic hz);
    @(negedge tck);
    #1; tms = m; tdi = d;
    #1; o = tdo; en = tdoEn; hz = highzEn;
  endtask

  // from Run-Test/Idle: full scan of n bits, back to Run-Test/Idle
  task automatic scan(input bit isIr, input int n, input logic [31:0] din,
                      output logic [31:0] dout, output bit enOk);
    logic o, en, hz;
    dout = '0; enOk = 1;
    tick(1, 0, o, en, hz);
    if (isIr) tick(1, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, en, hz);
      dout[i] = o;
      if (!en) enOk = 0;
    end
    tick(1, 0, o, en, hz);
    if (en) enOk = 0;
    tick(0, 0, o, en, hz);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    bit enOk;
    logic o, en, hz;
    string tag;

    // reset state, R1
    #5;
    check(tdoEn == 1'b0, "R1 tdoEn in reset", {31'd0, tdoEn}, 32'd0);
    check(highzEn == 1'b0, "R1 highzEn in reset", {31'd0, highzEn}, 32'd0);
    @(negedge tck); #1; trstN = 1'b1;
    tick(0, 0, o, en, hz);

    // default instruction after reset and word layout, R10
    scan(0, 32, 32'hDEAD_BEEF, got, enOk);
    check(got == IDW, "R5 default instruction reads identification", got, IDW);
    check(got[31:28] == VER, "R10 version field", {28'd0, got[31:28]}, {28'd0, VER});
    check(got[27:12] == PART, "R10 part field", {16'd0, got[27:12]}, {16'd0, PART});
    check(got[11:0] == MFR, "R10 manufacturer field", {20'd0, got[11:0]}, {20'd0, MFR});

    // vector table
    for (int v = 0; v < NV; v++) begin
      scan(1, 5, {27'd0, VECS[v].op}, got, enOk);
      check(got[4:0] == 5'b00001, "R4 instruction capture", {27'd0, got[4:0]}, 32'd1);
      check(enOk, "R3 tdoEn across instruction scan", {31'd0, enOk}, 32'd1);
      tick(0, 0, o, en, hz);
      check(en == 1'b0, "R3 tdoEn in idle", {31'd0, en}, 32'd0);
      tag = VECS[v].hz ? "R8 float instruction" :
            (VECS[v].op == 5'b11111 ? "R7 bypass instruction" : "R9 other code");
      check(hz == VECS[v].hz, {tag, " highzEn"}, {31'd0, hz}, {31'd0, VECS[v].hz});
      scan(0, 32, VECS[v].din, got, enOk);
      if (VECS[v].isId) begin
        exp = IDW;
        tag = "R5 identification scan, R6 unaltered";
      end else begin
        exp = {VECS[v].din[30:0], 1'b0};
      end
      check(got == exp, {tag, " data"}, got, exp);
      check(enOk, "R3 tdoEn across data scan", {31'd0, enOk}, 32'd1);
    end

    // R6: repeated identification scans with different data return the same word
    scan(1, 5, 32'h1E, got, enOk);
    scan(0, 32, 32'h5555_AAAA, got, enOk);
    scan(0, 32, 32'h0000_0000, got, enOk);
    check(got == IDW, "R6 second identification capture", got, IDW);

    // R2: float instruction active, five high mode edges from inside Shift-DR
    scan(1, 5, 32'h08, got, enOk);
    tick(0, 0, o, en, hz);
    check(hz == 1'b1, "R8 float set before reset sequence", {31'd0, hz}, 32'd1);
    tick(1, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    for (int k = 0; k < 5; k++) tick(1, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    check(hz == 1'b0, "R2 highzEn after five high edges", {31'd0, hz}, 32'd0);
    check(en == 1'b0, "R2 tdoEn in reset state", {31'd0, en}, 32'd0);
    scan(0, 32, 32'hFFFF_FFFF, got, enOk);
    check(got == IDW, "R2 identification instruction after reset", got, IDW);

    // R1: asynchronous reset midway through a cycle while shifting
    scan(1, 5, 32'h08, got, enOk);
    tick(1, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    tick(0, 0, o, en, hz);
    tick(0, 1, o, en, hz);
    check(en == 1'b1 && hz == 1'b1, "R1 shifting with float before reset", {30'd0, en, hz}, 32'd3);
    #1; trstN = 1'b0;
    #0.5;
    check(highzEn == 1'b0, "R1 highzEn drops without clock", {31'd0, highzEn}, 32'd0);
    check(tdoEn == 1'b0, "R1 tdoEn drops without clock", {31'd0, tdoEn}, 32'd0);
    @(negedge tck); #1; tms = 1'b0; trstN = 1'b1;
    tick(0, 0, o, en, hz);
    scan(0, 32, 32'h3C3C_3C3C, got, enOk);
    check(got == IDW, "R1 identification instruction after reset", got, IDW);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule